// File: doc/BRIEF.md
# Fetch-Path Breakpoint Patcher

This block sits between the instruction memory and the instruction decoder of a small microcontroller core. It holds a small table of breakpoint entries. Each entry has a word address, the instruction word that the breakpoint displaces, and an armed bit. When the core fetches an address whose entry is armed, the block hands the decoder the fixed break opcode 0x9598 instead of the memory word. In the same cycle it raises a hit signal, so the run controller can stop free-running execution.

A host-side debug port issues four commands: insert a breakpoint, remove a breakpoint, arm every entry, and disarm every entry. An insert carries the original instruction word, which the host has read from memory, and that word is stored with the address. While an entry is disarmed, a fetch of its address returns the stored original word. Removing an entry frees its slot, and fetches of that address then see the plain memory word again. Entries are matched on the address alone.

Top module: `bp_fetch_patch`

## Requirements
- R1: After reset the table is empty and every entry is disarmed. Every fetch returns `memWord` unchanged, `bpHit` is low, and `cmdErr` is low.
- R2: A fetch whose address matches a valid, armed entry returns 0x9598 on `fetchWord` in the same cycle. `bpHit` is high in that cycle only when `fetchValid` is high.
- R3: A fetch of an address that has no valid entry returns `memWord` unchanged, with `bpHit` low.
- R4: A remove of a stored address frees that entry, and later fetches of that address return `memWord`. A remove of an address not in the table leaves every entry as it was and raises no error.
- R5: A disarm-all command (`cmdOp` = 3) keeps every entry. A later fetch of a stored address returns the word that was captured when it was inserted, with `bpHit` low.
- R6: An arm-all command (`cmdOp` = 2) re-arms every valid entry and never alters a stored original word, even when the memory word at that address is itself 0x9598.
- R7: An insert (`cmdOp` = 0) of an address that is already stored is rejected. The table is unchanged, so the first saved word is kept, and `cmdErr` is high for the one cycle after the command.
- R8: An insert when all 8 entries are valid is rejected, with `cmdErr` high for one cycle. Once a remove (`cmdOp` = 1) has freed a slot, an insert succeeds again.
- R9: A command changes the table from the clock edge that accepts it. A fetch in the same cycle as the command still sees the old table.
- R10: Matching uses the address only. The value on `memWord` has no effect on whether an armed entry substitutes the break opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 1 | Core fetch strobe |
| fetchAddr | input | 16 | Fetch word address |
| memWord | input | 16 | Word read from instruction memory |
| fetchWord | output | 16 | Word passed on to the decoder |
| bpHit | output | 1 | Armed breakpoint fetched |
| cmdValid | input | 1 | Debug command strobe |
| cmdOp | input | 2 | 0 insert, 1 remove, 2 arm all, 3 disarm all |
| cmdAddr | input | 16 | Word address for insert or remove |
| cmdWord | input | 16 | Original instruction word captured by insert |
| cmdErr | output | 1 | Insert rejected (pulse, one cycle after the command) |

## Verification
The bench sweeps fetch addresses across the whole table after each command and compares the results against a reference table that it keeps itself.

The disarm, arm, disarm sequence is run with the memory word forced to the break opcode. A design that recaptured the saved words on arm would then return 0x9598 where the original word belongs.

A duplicate insert carrying a different word is followed by a disarmed fetch, which catches a design that overwrites the first saved word.

The ninth insert into a full table must raise `cmdErr` and leave all eight entries intact. A fetch driven in the same cycle as an insert must still see the old table, which exposes a design that makes command decode combinational.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CMD_INSERT = 2'd0,
    CMD_REMOVE = 2'd1,
    CMD_ARM    = 2'd2,
    CMD_DISARM = 2'd3
  } bpCmd_e;

  // strobes from control to the table datapath
  typedef struct packed {
    logic load;
    logic drop;
    logic armAll;
    logic disarmAll;
  } bpStrobe_t;
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] cmdMatchVec,
  output bpStrobe_t          strb,
  output logic [ENTRIES-1:0] loadSel,
  output logic [ENTRIES-1:0] dropSel,
  output logic               cmdErr
);
  bpCmd_e             op;
  logic [ENTRIES-1:0] freeVec;
  logic               isInsert;
  logic               tableFull;
  logic               dupAddr;
  logic               reject;

  assign op        = bpCmd_e'(cmdOp);
  assign freeVec   = ~validVec;
  assign tableFull = &validVec;
  assign dupAddr   = |cmdMatchVec;
  assign isInsert  = cmdValid && (op == CMD_INSERT);
  assign reject    = isInsert && (dupAddr || tableFull);

  // lowest free slot, as a one-hot vector
  assign loadSel = freeVec & (~freeVec + ENTRIES'(1));
  assign dropSel = cmdMatchVec;

  always_comb begin
    strb           = '0;
    strb.load      = isInsert && !reject;
    strb.drop      = cmdValid && (op == CMD_REMOVE) && dupAddr;
    strb.armAll    = cmdValid && (op == CMD_ARM);
    strb.disarmAll = cmdValid && (op == CMD_DISARM);
  end

  always_ff @(posedge clk) begin
    if (rst) cmdErr <= 1'b0;
    else     cmdErr <= reject;
  end
endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int          ENTRIES    = 8,
  parameter int          ADDR_W     = 16,
  parameter int          WORD_W     = 16,
  parameter logic [15:0] BREAK_WORD = 16'h9598
) (
  input  logic               clk,
  input  logic               rst,
  input  bpStrobe_t          strb,
  input  logic [ENTRIES-1:0] loadSel,
  input  logic [ENTRIES-1:0] dropSel,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [WORD_W-1:0]  cmdWord,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchAddr,
  input  logic [WORD_W-1:0]  memWord,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] cmdMatchVec,
  output logic [WORD_W-1:0]  fetchWord,
  output logic               bpHit
);
  localparam logic [WORD_W-1:0] BRK = WORD_W'(BREAK_WORD);

  logic [ENTRIES-1:0] entArmed;
  logic [ADDR_W-1:0]  entAddr [ENTRIES];
  logic [WORD_W-1:0]  entWord [ENTRIES];
  logic [ENTRIES-1:0] fetchMatch;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        validVec[i] <= 1'b0;
        entArmed[i] <= 1'b0;
        entAddr[i]  <= '0;
        entWord[i]  <= '0;
      end else if (strb.load && loadSel[i]) begin
        validVec[i] <= 1'b1;
        entArmed[i] <= 1'b1;
        entAddr[i]  <= cmdAddr;
        entWord[i]  <= cmdWord;
      end else if (strb.drop && dropSel[i]) begin
        validVec[i] <= 1'b0;
        entArmed[i] <= 1'b0;
      end else if (strb.armAll) begin
        entArmed[i] <= validVec[i];
      end else if (strb.disarmAll) begin
        entArmed[i] <= 1'b0;
      end
    end
    assign cmdMatchVec[i] = validVec[i] && (entAddr[i] == cmdAddr);
    assign fetchMatch[i]  = validVec[i] && (entAddr[i] == fetchAddr);
  end

  logic [WORD_W-1:0] savedWord;
  logic              anyMatch;
  logic              armedMatch;

  always_comb begin
    savedWord  = '0;
    anyMatch   = 1'b0;
    armedMatch = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      savedWord  = savedWord | (entWord[i] & {WORD_W{fetchMatch[i]}});
      anyMatch   = anyMatch | fetchMatch[i];
      armedMatch = armedMatch | (fetchMatch[i] & entArmed[i]);
    end
  end

  assign fetchWord = armedMatch ? BRK : (anyMatch ? savedWord : memWord);
  assign bpHit     = fetchValid && armedMatch;
endmodule

// File: rtl/bp_fetch_patch.sv
module bp_fetch_patch
  import bp_pkg::*;
#(
  parameter int          ENTRIES    = 8,
  parameter int          ADDR_W     = 16,
  parameter int          WORD_W     = 16,
  parameter logic [15:0] BREAK_WORD = 16'h9598
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [WORD_W-1:0] memWord,
  output logic [WORD_W-1:0] fetchWord,
  output logic              bpHit,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [WORD_W-1:0] cmdWord,
  output logic              cmdErr
);
  bpStrobe_t          strb;
  logic [ENTRIES-1:0] loadSel;
  logic [ENTRIES-1:0] dropSel;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] cmdMatchVec;

  bp_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .validVec(validVec), .cmdMatchVec(cmdMatchVec), .strb(strb),
    .loadSel(loadSel), .dropSel(dropSel), .cmdErr(cmdErr)
  );

  bp_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BREAK_WORD(BREAK_WORD)
  ) u_table (
    .clk(clk), .rst(rst), .strb(strb), .loadSel(loadSel), .dropSel(dropSel),
    .cmdAddr(cmdAddr), .cmdWord(cmdWord), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .memWord(memWord), .validVec(validVec),
    .cmdMatchVec(cmdMatchVec), .fetchWord(fetchWord), .bpHit(bpHit)
  );
endmodule

// File: rtl/bp_fetch_patch_chk.sv
module bp_fetch_patch_chk #(
  parameter int          ADDR_W     = 16,
  parameter int          WORD_W     = 16,
  parameter logic [15:0] BREAK_WORD = 16'h9598
) (
  input logic              clk,
  input logic              rst,
  input logic              fetchValid,
  input logic [WORD_W-1:0] fetchWord,
  input logic              bpHit,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic              cmdErr
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bpHit && !cmdErr));

  a_r2_hit_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    bpHit |-> fetchValid);

  a_r2_hit_gives_break: assert property (@(posedge clk) disable iff (rst)
    bpHit |-> (fetchWord == WORD_W'(BREAK_WORD)));

  a_r5_disarm_stops_hits: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 2'd3) |=> !bpHit);

  a_r7_err_only_after_insert: assert property (@(posedge clk) disable iff (rst)
    cmdErr |-> $past(cmdValid && cmdOp == 2'd0));
endmodule

bind bp_fetch_patch bp_fetch_patch_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BREAK_WORD(BREAK_WORD)
) u_chk (
  .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchWord(fetchWord),
  .bpHit(bpHit), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdErr(cmdErr)
);

// File: tb/sim_bp_fetch_patch.sv
`timescale 1ns/1ps
module sim_bp_fetch_patch;
  localparam logic [15:0] BRK = 16'h9598;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetchValid = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic [15:0] memWord = '0;
  logic [15:0] fetchWord;
  logic bpHit;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [15:0] cmdAddr = '0;
  logic [15:0] cmdWord = '0;
  logic cmdErr;

  int checks = 0;
  int fails = 0;

  // reference table kept by the bench
  logic        mValid [8];
  logic        mArmed [8];
  logic [15:0] mAddr  [8];
  logic [15:0] mSaved [8];

  always #2 clk = ~clk;

  bp_fetch_patch u0 (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .memWord(memWord), .fetchWord(fetchWord), .bpHit(bpHit),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdWord(cmdWord),
    .cmdErr(cmdErr)
  );

  function automatic logic [15:0] memOf(input logic [15:0] a, input bit forceBrk);
    if (forceBrk) return BRK;
    return {a[7:0] ^ 8'h3C, a[7:0] * 8'd7};
  endfunction

  task automatic cmp(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic fetchCheck(input string req, input logic [15:0] a, input bit fv, input bit forceBrk);
    logic [15:0] expWord;
    logic        expHit;
    @(negedge clk);
    fetchValid = fv;
    fetchAddr  = a;
    memWord    = memOf(a, forceBrk);
    #1;
    expWord = memWord;
    expHit  = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (mValid[i] && mAddr[i] == a) begin
        expWord = mArmed[i] ? BRK : mSaved[i];
        expHit  = mArmed[i] && fv;
      end
    end
    cmp({req, " word"}, fetchWord, expWord);
    cmp({req, " hit"}, {15'd0, bpHit}, {15'd0, expHit});
  endtask

  task automatic sweep(input string req, input bit fv, input bit forceBrk);
    for (int a = 0; a < 48; a++) fetchCheck(req, 16'(a), fv, forceBrk);
    fetchCheck(req, 16'hFFFF, fv, forceBrk);
  endtask

  // reference behaviour of one command; returns expected error
  function automatic bit modelCmd(input logic [1:0] op, input logic [15:0] a, input logic [15:0] w);
    int hitIdx;
    int freeIdx;
    hitIdx  = -1;
    freeIdx = -1;
    for (int i = 0; i < 8; i++) begin
      if (mValid[i] && mAddr[i] == a) hitIdx = i;
      if (!mValid[i] && freeIdx < 0) freeIdx = i;
    end
    case (op)
      2'd0: begin
        if (hitIdx >= 0 || freeIdx < 0) return 1'b1;
        mValid[freeIdx] = 1'b1; mArmed[freeIdx] = 1'b1;
        mAddr[freeIdx] = a; mSaved[freeIdx] = w;
      end
      2'd1: if (hitIdx >= 0) begin mValid[hitIdx] = 1'b0; mArmed[hitIdx] = 1'b0; end
      2'd2: for (int i = 0; i < 8; i++) mArmed[i] = mValid[i];
      default: for (int i = 0; i < 8; i++) mArmed[i] = 1'b0;
    endcase
    return 1'b0;
  endfunction

  task automatic doCmd(input string req, input logic [1:0] op, input logic [15:0] a, input logic [15:0] w);
    bit expErr;
    @(negedge clk);
    fetchValid = 1'b0;
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdWord = w;
    @(negedge clk);
    cmdValid = 1'b0;
    expErr = modelCmd(op, a, w);
    cmp({req, " err"}, {15'd0, cmdErr}, {15'd0, expErr});
    @(negedge clk);
    cmp({req, " err one cycle"}, {15'd0, cmdErr}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mValid[i] = 1'b0; mArmed[i] = 1'b0; mAddr[i] = '0; mSaved[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cmp("R1 err after reset", {15'd0, cmdErr}, 16'd0);
    sweep("R1", 1'b1, 1'b0);

    // R2, R3, R10: three breakpoints, normal and forced memory words
    doCmd("R2 insert", 2'd0, 16'd3, 16'h1003);
    doCmd("R2 insert", 2'd0, 16'd10, 16'h100A);
    doCmd("R2 insert", 2'd0, 16'd17, 16'h1011);
    sweep("R2/R3", 1'b1, 1'b0);
    sweep("R10", 1'b1, 1'b1);
    sweep("R2 fetch not valid", 1'b0, 1'b0);

    // R7: duplicate insert with another word
    doCmd("R7 duplicate", 2'd0, 16'd10, 16'hDEAD);

    // R8: fill the table, then overflow
    for (int k = 0; k < 5; k++) doCmd("R8 fill", 2'd0, 16'(20 + k), 16'(16'h2000 + k));
    doCmd("R8 full insert", 2'd0, 16'd30, 16'h3030);
    sweep("R8 after full", 1'b1, 1'b0);

    // R5, R6: disarm, arm with forced break memory, disarm
    doCmd("R5 disarm", 2'd3, 16'd0, 16'd0);
    sweep("R5/R7", 1'b1, 1'b0);
    doCmd("R6 arm", 2'd2, 16'd0, 16'd0);
    sweep("R6 armed", 1'b1, 1'b1);
    doCmd("R6 disarm", 2'd3, 16'd0, 16'd0);
    sweep("R6 saved kept", 1'b1, 1'b1);
    doCmd("R6 arm", 2'd2, 16'd0, 16'd0);

    // R4: remove present and absent
    doCmd("R4 remove", 2'd1, 16'd10, 16'd0);
    doCmd("R4 remove absent", 2'd1, 16'd99, 16'd0);
    sweep("R4", 1'b1, 1'b0);
    doCmd("R8 insert after free", 2'd0, 16'd30, 16'h3030);
    sweep("R8 reuse", 1'b1, 1'b0);

    // R9: fetch in the command cycle sees the old table
    doCmd("R9 free slot", 2'd1, 16'd3, 16'd0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd0; cmdAddr = 16'd40; cmdWord = 16'h4040;
    fetchValid = 1'b1; fetchAddr = 16'd40; memWord = memOf(16'd40, 1'b0);
    #1;
    cmp("R9 same cycle word", fetchWord, memOf(16'd40, 1'b0));
    cmp("R9 same cycle hit", {15'd0, bpHit}, 16'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    void'(modelCmd(2'd0, 16'd40, 16'h4040));
    #1;
    cmp("R9 next cycle word", fetchWord, BRK);
    cmp("R9 next cycle hit", {15'd0, bpHit}, 16'd1);
    sweep("R9", 1'b1, 1'b0);

    // R1: reset clears all entries
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 8; i++) begin mValid[i] = 1'b0; mArmed[i] = 1'b0; end
    @(negedge clk);
    rst = 1'b0;
    sweep("R1 re-reset", 1'b1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule